// File: doc/BRIEF.md
# Converter Enable and Fault Supervisor

This block decides when the stages of a two-stage switching converter may run. Its inputs are single-bit comparator flags: line undervoltage, two bias-supply levels (regulation reached, and a lower hold level), reference valid, soft-start above its shutdown level, and a pair of over-temperature flags (trip and release). Every flag is asynchronous to the block clock and passes through a two-flop synchronizer before any decision uses it.

The outputs gate the front buck stage, keep the alternating push-pull stage running, ask the soft-start capacitor to discharge, switch the line hysteresis current source, and ask the bias regulator to shut off. The buck stage and the push-pull stage have separate enable domains. The buck stage depends on line, bias, soft-start, reference and temperature. The push-pull stage depends only on the reference and on temperature. A four-state controller (off, starting, running, fault) sequences the buck enable and the soft-start discharge.

Top module: `sup_top`

## Requirements
- R1: `buck_en` rises only after `line_ok_a`, `vcc_reg_a`, `vcc_hold_a`, `ref_ok_a` and `ss_above_a` are all high and the thermal standby is inactive.
- R2: While running, `buck_en` stays high if `vcc_reg_a` alone falls but `vcc_hold_a` stays high. It falls when line, hold level, reference or soft-start drops, or when standby begins.
- R3: `pp_run` equals the synchronized reference-valid flag, gated only by thermal standby. Line, bias and soft-start faults have no effect on it.
- R4: `uvlo_hyst_on` follows the synchronized line flag: on while the line is above threshold, off below it.
- R5: `reg_off` is high while the line is below threshold or thermal standby is active. A low line leaves `pp_run` unaffected.
- R6: `ss_discharge` is high while a line-low, hold-level-low or standby fault is present. When all three clear, it falls and the controller restarts, so `buck_en` returns once soft-start is again above its threshold.
- R7: Thermal standby is set by `ot_trip_a`, where trip wins over release. It is cleared by `ot_release_a` while trip is low, and it holds its value while both are low. In standby `buck_en` and `pp_run` are low and `reg_off` is high.
- R8: While `rst_n` is low: `buck_en`, `pp_run`, `ss_discharge` and `uvlo_hyst_on` are 0, and `reg_off` is 1.
- R9: A flag change applied between clock edges reaches `uvlo_hyst_on` after the second rising edge. It reaches `buck_en` and `ss_discharge` after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_ok_a | input | 1 | Line above undervoltage threshold |
| vcc_reg_a | input | 1 | Bias supply has reached regulation |
| vcc_hold_a | input | 1 | Bias supply above its low (drop-out) threshold |
| ref_ok_a | input | 1 | Reference output valid |
| ss_above_a | input | 1 | Soft-start above its shutdown threshold |
| ot_trip_a | input | 1 | Die temperature above trip point |
| ot_release_a | input | 1 | Die temperature below release point |
| buck_en | output | 1 | Buck stage outputs may switch |
| pp_run | output | 1 | Push-pull outputs may alternate |
| ss_discharge | output | 1 | Discharge the soft-start capacitor |
| uvlo_hyst_on | output | 1 | Line hysteresis current source on |
| reg_off | output | 1 | Request bias regulator shutdown |

## Verification
The hardest situation to reach is a running buck stage whose entry condition has partly gone away. Regulation has dropped but the hold level remains, or soft-start falls while nothing else is wrong. Only the sequence leading into the running state makes this observable. The bench sweeps every flag combination in an interleaved order, forcing half the steps to near-healthy values so the running state is entered and left often. It adds directed sequences that drop regulation alone, walk the thermal trip/hold/release cycle, and time the synchronizer latency edge by edge.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_STARTUP = 2'd1,
    ST_RUN     = 2'd2,
    ST_FAULT   = 2'd3
  } sup_state_e;

  localparam int NUM_FLAGS  = 7;
  localparam int IX_LINE    = 0;
  localparam int IX_VREG    = 1;
  localparam int IX_VHOLD   = 2;
  localparam int IX_REF     = 3;
  localparam int IX_SS      = 4;
  localparam int IX_OTTRIP  = 5;
  localparam int IX_OTREL   = 6;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg[g] <= '0;
        end else begin
          if (g == 0) stg[g] <= d_async;
          else        stg[g] <= stg[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg[LAST];
endmodule

// File: rtl/sup_thermal.sv
module sup_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic release_ok,
  output logic hot
);
  logic hot_nxt;
  logic hot_upd;

  always_comb begin
    hot_upd = trip | release_ok;
    hot_nxt = trip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hot <= 1'b0;
    else if (hot_upd) hot <= hot_nxt;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && !release_ok) |=> $stable(hot));
  p_trip_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> hot);
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_ok,
  input  logic       vcc_reg,
  input  logic       vcc_hold,
  input  logic       ref_ok,
  input  logic       ss_above,
  input  logic       hot,
  output sup_state_e state,
  output logic       buck_en,
  output logic       ss_discharge
);
  sup_state_e state_nxt;
  logic       fault_any;

  always_comb begin
    fault_any = hot | ~line_ok | ~vcc_hold;
    state_nxt = state;
    if (fault_any) begin
      state_nxt = ST_FAULT;
    end else if (state == ST_FAULT) begin
      state_nxt = ref_ok ? ST_STARTUP : ST_OFF;
    end else if (!ref_ok) begin
      state_nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:     state_nxt = ST_STARTUP;
        ST_STARTUP: state_nxt = (vcc_reg && ss_above) ? ST_RUN : ST_STARTUP;
        ST_RUN:     state_nxt = ss_above ? ST_RUN : ST_STARTUP;
        default:    state_nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= state_nxt;
  end

  assign buck_en      = (state == ST_RUN);
  assign ss_discharge = (state == ST_FAULT);

  p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buck_en) |-> $past(line_ok && vcc_reg && vcc_hold && ref_ok && ss_above && !hot));
  p_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (buck_en && (!line_ok || !vcc_hold || !ref_ok || !ss_above || hot)) |=> !buck_en);
  p_fault_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_discharge && fault_any) |=> ss_discharge);
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_discharge && buck_en));
endmodule

// File: rtl/sup_top.sv
module sup_top
  import sup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_ok_a,
  input  logic vcc_reg_a,
  input  logic vcc_hold_a,
  input  logic ref_ok_a,
  input  logic ss_above_a,
  input  logic ot_trip_a,
  input  logic ot_release_a,
  output logic buck_en,
  output logic pp_run,
  output logic ss_discharge,
  output logic uvlo_hyst_on,
  output logic reg_off
);
  logic [1:0]           rst_pipe;
  logic                 rst_n_i;
  logic [NUM_FLAGS-1:0] flags_a;
  logic [NUM_FLAGS-1:0] flags_s;
  logic                 hot;
  sup_state_e           state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  always_comb begin
    flags_a            = '0;
    flags_a[IX_LINE]   = line_ok_a;
    flags_a[IX_VREG]   = vcc_reg_a;
    flags_a[IX_VHOLD]  = vcc_hold_a;
    flags_a[IX_REF]    = ref_ok_a;
    flags_a[IX_SS]     = ss_above_a;
    flags_a[IX_OTTRIP] = ot_trip_a;
    flags_a[IX_OTREL]  = ot_release_a;
  end

  sup_sync #(.WIDTH(NUM_FLAGS), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .d_async (flags_a),
    .q_sync  (flags_s)
  );

  sup_thermal u_thermal (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .trip       (flags_s[IX_OTTRIP]),
    .release_ok (flags_s[IX_OTREL]),
    .hot        (hot)
  );

  sup_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .line_ok      (flags_s[IX_LINE]),
    .vcc_reg      (flags_s[IX_VREG]),
    .vcc_hold     (flags_s[IX_VHOLD]),
    .ref_ok       (flags_s[IX_REF]),
    .ss_above     (flags_s[IX_SS]),
    .hot          (hot),
    .state        (state),
    .buck_en      (buck_en),
    .ss_discharge (ss_discharge)
  );

  assign pp_run       = flags_s[IX_REF] & ~hot;
  assign uvlo_hyst_on = flags_s[IX_LINE];
  assign reg_off      = ~flags_s[IX_LINE] | hot;

  p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (hot && $past(hot)) |-> (state == ST_FAULT));
endmodule

// File: tb/tb_sup_top.sv
module tb_sup_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;

  logic clk, rst_n;
  logic line_ok_a, vcc_reg_a, vcc_hold_a, ref_ok_a, ss_above_a, ot_trip_a, ot_release_a;
  logic buck_en, pp_run, ss_discharge, uvlo_hyst_on, reg_off;

  int n_chk, n_bad;
  bit finished;
  int m_state;
  bit m_hot;

  sup_top dut (
    .clk(clk), .rst_n(rst_n),
    .line_ok_a(line_ok_a), .vcc_reg_a(vcc_reg_a), .vcc_hold_a(vcc_hold_a),
    .ref_ok_a(ref_ok_a), .ss_above_a(ss_above_a), .ot_trip_a(ot_trip_a),
    .ot_release_a(ot_release_a),
    .buck_en(buck_en), .pp_run(pp_run), .ss_discharge(ss_discharge),
    .uvlo_hyst_on(uvlo_hyst_on), .reg_off(reg_off)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [6:0] c);
    line_ok_a = c[0]; vcc_reg_a = c[1]; vcc_hold_a = c[2]; ref_ok_a = c[3];
    ss_above_a = c[4]; ot_trip_a = c[5]; ot_release_a = c[6];
  endtask

  // Reference model: 0 off, 1 starting, 2 running, 3 fault
  task automatic model(input logic [6:0] c);
    bit ln, vr, vh, rf, ss;
    ln = c[0]; vr = c[1]; vh = c[2]; rf = c[3]; ss = c[4];
    if (c[5]) m_hot = 1'b1;
    else if (c[6]) m_hot = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (m_hot || !ln || !vh)   m_state = 3;
      else if (m_state == 3)     m_state = rf ? 1 : 0;
      else if (!rf)              m_state = 0;
      else if (m_state == 0)     m_state = 1;
      else if (m_state == 1)     m_state = (vr && ss) ? 2 : 1;
      else                       m_state = ss ? 2 : 1;
    end
  endtask

  task automatic step_check(input logic [6:0] c);
    @(negedge clk);
    drive(c);
    repeat (SETTLE) @(negedge clk);
    model(c);
    chk("R1/R2 buck_en", buck_en, m_state == 2);
    chk("R6 ss_discharge", ss_discharge, m_state == 3);
    chk("R3/R7 pp_run", pp_run, c[3] & ~m_hot);
    chk("R4 uvlo_hyst_on", uvlo_hyst_on, c[0]);
    chk("R5 reg_off", reg_off, ~c[0] | m_hot);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0; m_state = 0; m_hot = 0;
    rst_n = 1'b0;
    drive(7'h7f);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 buck_en", buck_en, 1'b0);
    chk("R8 pp_run", pp_run, 1'b0);
    chk("R8 ss_discharge", ss_discharge, 1'b0);
    chk("R8 uvlo_hyst_on", uvlo_hyst_on, 1'b0);
    chk("R8 reg_off", reg_off, 1'b1);
    drive(7'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Near-exhaustive interleaved sweep; odd steps biased towards health
    for (int i = 0; i < 512; i++) begin
      logic [6:0] c;
      c = 7'((i * 37 + (i >> 7) * 11) & 127);
      if (i[0]) c = (c | 7'b100_0101) & 7'b101_1111;
      step_check(c);
    end

    // R2: regulation flag alone drops while running
    step_check(7'b101_1111);
    chk("R2 running", buck_en, 1'b1);
    step_check(7'b101_1101);
    chk("R2 hold level keeps buck", buck_en, 1'b1);
    step_check(7'b101_1001);
    chk("R2 hold level low drops buck", buck_en, 1'b0);
    chk("R6 discharge on hold low", ss_discharge, 1'b1);
    chk("R5 line ok keeps pp", pp_run, 1'b1);

    // R6: recovery restarts and re-enables
    step_check(7'b100_1111);
    chk("R6 restart waits soft-start", buck_en, 1'b0);
    chk("R6 discharge released", ss_discharge, 1'b0);
    step_check(7'b101_1111);
    chk("R6 running again", buck_en, 1'b1);

    // R7: trip, hold, release
    step_check(7'b011_1111);
    chk("R7 standby buck", buck_en, 1'b0);
    chk("R7 standby pp", pp_run, 1'b0);
    step_check(7'b001_1111);
    chk("R7 standby held", pp_run, 1'b0);
    step_check(7'b111_1111);
    chk("R7 trip wins", reg_off, 1'b1);
    step_check(7'b101_1111);
    chk("R7 released", pp_run, 1'b1);
    chk("R7 released buck", buck_en, 1'b1);

    // R9: latency through synchronizer and state register
    @(negedge clk);
    line_ok_a = 1'b0;
    @(negedge clk);
    chk("R9 hyst after 1 edge", uvlo_hyst_on, 1'b1);
    @(negedge clk);
    chk("R9 hyst after 2 edges", uvlo_hyst_on, 1'b0);
    chk("R9 buck after 2 edges", buck_en, 1'b1);
    @(negedge clk);
    chk("R9 buck after 3 edges", buck_en, 1'b0);
    chk("R9 discharge after 3 edges", ss_discharge, 1'b1);
    chk("R5 line low leaves pp", pp_run, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule